// File: doc/BRIEF.md
# Receive Descriptor and Status Ring Manager

This block keeps two circular queues in system memory on behalf of a bus-mastering network receiver. The first queue holds descriptors that software fills with free buffers; the second holds status entries that the block writes back once a frame has landed. For every completed frame it reads the buffer index from the descriptor it owns next. It then writes a two-word status entry that carries that index, the frame length and the error flags. It advances both queue pointers and raises a receive interrupt.

Software programs each queue through a base address, a byte length and a current address, and hands entries back by writing a count to a per-queue credit register. The MAC receive path and payload movement sit outside the block: a single frame-complete handshake carrying a length and six flag bits stands in for them. Memory is reached through a one-transfer-at-a-time request/acknowledge port.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After synchronous reset every readable register returns 0, `irq` is 0, `frm_ready` is 0 and `mem_req` is 0.
- R2: Writing 1 to bit 0 of the control register (offset 0x00) makes bit 3 of the status register (offset 0x04) read 1. `frm_ready` is high only while that bit is set and no frame is in progress. Writing 0 clears it again once idle.
- R3: Writing N to a credit register (0x1C for descriptors, 0x2C for status) adds N to that queue's available count, readable at 0x30 and 0x34 respectively. Each write changes only its own queue.
- R4: For each accepted frame the block first reads the word at descriptor current address + 4 and takes bits 30:16 as the buffer index; bit 31 of that word does not affect the index.
- R5: The first status word is written at status current address. It sets bit 31 (done), bit 29 (end of frame) and bit 28 (end of buffer), and sets bit 30 when no error flag is set. Bit 21 is set when any error flag is set. It copies frame flags [5] overrun, [4] framing, [3] runt, [2] extra data, [1] CRC error and [0] CRC included into bits 20, 19, 18, 17, 16 and 15. The error flags are bits 5 to 1.
- R6: The second status word is written at status current address + 4. It holds bit 31 set, the buffer index in bits 30:16 and the frame length in bits 15:0.
- R7: After each frame each current address grows by 8. When the result reaches base + length, it becomes the base instead. Base, length and current sit at +0x0, +0x4 and +0x8 of 0x10 (descriptors) and 0x20 (status), and each queue wraps on its own length.
- R8: Each written frame lowers both available counts by one.
- R9: A frame accepted while either available count is 0 is dropped. No memory access follows, both counts and both current addresses stay unchanged, and the drop counter at 0x38 grows by one.
- R10: Every written frame sets bit 2 of the interrupt status register (0x0C), and writing 1 to that bit clears it. `irq` follows, one cycle later, that bit ANDed with the OR of the interrupt-enable bits 2:0 at 0x08.
- R11: Once `mem_req` is raised, `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data returns next cycle |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| frm_valid | input | 1 | Frame-complete event |
| frm_ready | output | 1 | Block can take a frame event |
| frm_len | input | 16 | Frame length in bytes |
| frm_flags | input | 6 | Frame flags, encoding per R5 |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions assume that software never credits a queue while the block is consuming from it in a way that would drive a count negative. They also assume the memory answers each request with exactly one acknowledge pulse. The stimulus obeys both rules: the bench credits only between frames, and its memory model raises `mem_ack` for a single cycle per transfer. It programs each queue length as a multiple of 8 with the current address at the base, so the wrap check compares against a reachable boundary.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STS0,
    ST_STS1
  } eng_state_t;

  localparam int IDX_W  = 15;
  localparam int LEN_W  = 16;
  localparam int FLAG_W = 6;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_STAT    = 8'h04;
  localparam logic [7:0] OFS_IEN     = 8'h08;
  localparam logic [7:0] OFS_ISTAT   = 8'h0C;
  localparam logic [7:0] OFS_RING0   = 8'h10;
  localparam logic [7:0] RING_STRIDE = 8'h10;
  localparam logic [7:0] SUB_BASE    = 8'h0;
  localparam logic [7:0] SUB_LEN     = 8'h4;
  localparam logic [7:0] SUB_CUR     = 8'h8;
  localparam logic [7:0] SUB_ENQ     = 8'hC;
  localparam logic [7:0] OFS_AVAIL0  = 8'h30;
  localparam logic [7:0] OFS_DROPS   = 8'h38;

  function automatic logic [31:0] sts_word0(input logic [FLAG_W-1:0] fl);
    logic bad;
    bad = |fl[5:1];
    sts_word0 = '0;
    sts_word0[31]    = 1'b1;
    sts_word0[30]    = ~bad;
    sts_word0[29]    = 1'b1;
    sts_word0[28]    = 1'b1;
    sts_word0[21]    = bad;
    sts_word0[20:15] = fl;
  endfunction

  function automatic logic [31:0] sts_word1(input logic [IDX_W-1:0] idx,
                                            input logic [LEN_W-1:0] len);
    sts_word1 = {1'b1, idx, len};
  endfunction

endpackage

// File: rtl/rxr_ring.sv
module rxr_ring #(
  parameter int AW          = 32,
  parameter int CNT_W       = 16,
  parameter int ENTRY_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_we,
  input  logic             len_we,
  input  logic             cur_we,
  input  logic             enq_we,
  input  logic [AW-1:0]    wdata,
  input  logic             consume,
  output logic [AW-1:0]    base,
  output logic [AW-1:0]    len,
  output logic [AW-1:0]    cur,
  output logic [CNT_W-1:0] avail
);

  localparam logic [AW-1:0] STEP = AW'(ENTRY_BYTES);

  logic [AW-1:0]    cur_inc;
  logic [AW-1:0]    cur_step;
  logic [CNT_W-1:0] enq_amt;
  logic [CNT_W-1:0] use_amt;

  assign cur_inc  = cur + STEP;
  assign cur_step = (cur_inc >= base + len) ? base : cur_inc;
  assign enq_amt  = enq_we ? wdata[CNT_W-1:0] : '0;
  assign use_amt  = {{(CNT_W-1){1'b0}}, consume};

  always_ff @(posedge clk) begin
    if (rst) begin
      base  <= '0;
      len   <= '0;
      cur   <= '0;
      avail <= '0;
    end else begin
      if (base_we) base <= wdata;
      if (len_we)  len  <= wdata;
      if (cur_we)       cur <= wdata;
      else if (consume) cur <= cur_step;
      avail <= avail + enq_amt - use_amt;
    end
  end

  // R8: an entry is only taken when one is available
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    consume |-> avail != '0);

  // R7: a consumed entry moves the pointer one step or back to base
  a_r7_step_or_wrap: assert property (@(posedge clk) disable iff (rst)
    (consume && !cur_we && !base_we && !len_we) |=>
      ((cur == $past(cur) + STEP) || (cur == base)));

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [FLAG_W-1:0] frm_flags,
  input  logic [AW-1:0]     desc_cur,
  input  logic [AW-1:0]     sts_cur,
  input  logic [CNT_W-1:0]  desc_avail,
  input  logic [CNT_W-1:0]  sts_avail,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              frm_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              consume,
  output logic              drop,
  output logic              busy
);

  localparam logic [AW-1:0] WORD1 = AW'(4);

  eng_state_t        state;
  logic [LEN_W-1:0]  len_q;
  logic [FLAG_W-1:0] fl_q;
  logic [IDX_W-1:0]  idx_q;
  logic              accept;
  logic              room;
  logic              unused_rdata;

  assign unused_rdata = ^{mem_rdata[31], mem_rdata[15:0]};

  assign frm_ready = (state == ST_IDLE) && active;
  assign accept    = frm_valid && frm_ready;
  assign room      = (desc_avail != '0) && (sts_avail != '0);
  assign drop      = accept && !room;
  assign consume   = (state == ST_STS1) && mem_ack;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      len_q     <= '0;
      fl_q      <= '0;
      idx_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && room) begin
            len_q    <= frm_len;
            fl_q     <= frm_flags;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= desc_cur + WORD1;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            idx_q     <= mem_rdata[30:16];
            mem_we    <= 1'b1;
            mem_addr  <= sts_cur;
            mem_wdata <= sts_word0(fl_q);
            state     <= ST_STS0;
          end
        end
        ST_STS0: begin
          if (mem_ack) begin
            mem_addr  <= sts_cur + WORD1;
            mem_wdata <= sts_word1(idx_q, len_q);
            state     <= ST_STS1;
          end
        end
        ST_STS1: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: a pending transfer keeps its request, direction and address
  a_r11_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: a dropped frame starts no memory traffic
  a_r9_drop_quiet: assert property (@(posedge clk) disable iff (rst)
    drop |=> !mem_req);

  // R4: every frame begins with a descriptor read
  a_r4_read_first: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> !mem_we);

endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr
  import rxr_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CNT_W       = 16,
  parameter int ENTRY_BYTES = 8,
  parameter int REG_AW      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [FLAG_W-1:0] frm_flags,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              irq
);

  localparam int NRING = 2;  // 0 = descriptors, 1 = status

  logic             rx_en;
  logic             rx_active;
  logic [2:0]       int_en;
  logic             rx_pend;
  logic [15:0]      drop_cnt;
  logic             consume;
  logic             drop;
  logic             busy;
  logic [31:0]      rd_mux;

  logic [AW-1:0]    r_base  [NRING];
  logic [AW-1:0]    r_len   [NRING];
  logic [AW-1:0]    r_cur   [NRING];
  logic [CNT_W-1:0] r_avail [NRING];

  function automatic logic [REG_AW-1:0] ring_reg(input int g, input logic [7:0] sub);
    ring_reg = REG_AW'(OFS_RING0 + 8'(g) * RING_STRIDE + sub);
  endfunction

  generate
    for (genvar g = 0; g < NRING; g++) begin : g_ring
      rxr_ring #(
        .AW          (AW),
        .CNT_W       (CNT_W),
        .ENTRY_BYTES (ENTRY_BYTES)
      ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .base_we (reg_wr && reg_addr == ring_reg(g, SUB_BASE)),
        .len_we  (reg_wr && reg_addr == ring_reg(g, SUB_LEN)),
        .cur_we  (reg_wr && reg_addr == ring_reg(g, SUB_CUR)),
        .enq_we  (reg_wr && reg_addr == ring_reg(g, SUB_ENQ)),
        .wdata   (AW'(reg_wdata)),
        .consume (consume),
        .base    (r_base[g]),
        .len     (r_len[g]),
        .cur     (r_cur[g]),
        .avail   (r_avail[g])
      );
    end
  endgenerate

  rxr_engine #(
    .AW    (AW),
    .CNT_W (CNT_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .active     (rx_active),
    .frm_valid  (frm_valid),
    .frm_len    (frm_len),
    .frm_flags  (frm_flags),
    .desc_cur   (r_cur[0]),
    .sts_cur    (r_cur[1]),
    .desc_avail (r_avail[0]),
    .sts_avail  (r_avail[1]),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .frm_ready  (frm_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .consume    (consume),
    .drop       (drop),
    .busy       (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en     <= 1'b0;
      rx_active <= 1'b0;
      int_en    <= '0;
      rx_pend   <= 1'b0;
      drop_cnt  <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == REG_AW'(OFS_CTRL)) rx_en  <= reg_wdata[0];
      if (reg_wr && reg_addr == REG_AW'(OFS_IEN))  int_en <= reg_wdata[2:0];
      rx_active <= rx_en || busy;
      if (consume)
        rx_pend <= 1'b1;
      else if (reg_wr && reg_addr == REG_AW'(OFS_ISTAT) && reg_wdata[2])
        rx_pend <= 1'b0;
      if (drop) drop_cnt <= drop_cnt + 16'd1;
      irq <= rx_pend && (|int_en);
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      REG_AW'(OFS_CTRL):       rd_mux[0]   = rx_en;
      REG_AW'(OFS_STAT):       rd_mux[3]   = rx_active;
      REG_AW'(OFS_IEN):        rd_mux[2:0] = int_en;
      REG_AW'(OFS_ISTAT):      rd_mux[2]   = rx_pend;
      REG_AW'(OFS_AVAIL0):     rd_mux      = 32'(r_avail[0]);
      REG_AW'(OFS_AVAIL0 + 4): rd_mux      = 32'(r_avail[1]);
      REG_AW'(OFS_DROPS):      rd_mux      = 32'(drop_cnt);
      default: ;
    endcase
    for (int g = 0; g < NRING; g++) begin
      if (reg_addr == ring_reg(g, SUB_BASE)) rd_mux = 32'(r_base[g]);
      if (reg_addr == ring_reg(g, SUB_LEN))  rd_mux = 32'(r_len[g]);
      if (reg_addr == ring_reg(g, SUB_CUR))  rd_mux = 32'(r_cur[g]);
    end
  end

  // R2: frame events are taken only while receive is active
  a_r2_ready_needs_active: assert property (@(posedge clk) disable iff (rst)
    frm_ready |-> rx_active);

  // R10: a written frame leaves the interrupt pending
  a_r10_frame_sets_pend: assert property (@(posedge clk) disable iff (rst)
    consume |=> rx_pend);

endmodule

// File: tb/rxr_ring_mgr_tb.sv
module rxr_ring_mgr_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [15:0] frm_len = '0;
  logic [5:0]  frm_flags = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  rxr_ring_mgr u_dut (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .frm_flags(frm_flags),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
  wr_t exp_q[$];
  logic [31:0] mem [0:255];
  int n_chk = 0, n_fail = 0, n_acc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      n_acc++;
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        if (exp_q.size() == 0) check("R9 unexpected write", mem_addr, 32'hFFFF_FFFF);
        else begin
          wr_t e;
          e = exp_q.pop_front();
          check("R7 status address", mem_addr, e.a);
          check(e.a[2] ? "R6 status word1" : "R5 status word0", mem_wdata, e.d);
        end
      end else mem_rdata <= mem[mem_addr[9:2]];
    end else mem_ack <= 1'b0;
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_w0(input logic [5:0] f);
    logic bad;
    bad = (f[5] | f[4] | f[3] | f[2] | f[1]);
    exp_w0 = 32'h3000_0000 | 32'h8000_0000;
    if (!bad) exp_w0 |= 32'h4000_0000;
    else      exp_w0 |= 32'h0020_0000;
    exp_w0 |= {11'd0, f, 15'd0};
  endfunction

  task automatic send_frame(input logic [15:0] len, input logic [5:0] fl,
                            input logic [14:0] idx, input logic [31:0] sa,
                            input bit dropped);
    if (!dropped) begin
      exp_q.push_back('{a: sa, d: exp_w0(fl)});
      exp_q.push_back('{a: sa + 32'd4, d: {1'b1, idx, len}});
    end
    @(negedge clk);
    while (!frm_ready) @(negedge clk);
    frm_valid = 1'b1; frm_len = len; frm_flags = fl;
    @(negedge clk);
    frm_valid = 1'b0;
    for (int k = 0; k < 100 && (exp_q.size() != 0 || !frm_ready); k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int acc0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) mem[8'h41 + 2*i] = ((32'd5 + i) << 16) | 32'd2048;
    mem[8'h43] |= 32'h8000_0000;  // entry 1 carries a set top bit (R4)
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 frm_ready", {31'd0, frm_ready}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    reg_read(8'h04, d); check("R1 status reg", d, 32'd0);
    reg_read(8'h18, d); check("R1 desc cur", d, 32'd0);
    reg_read(8'h30, d); check("R1 desc avail", d, 32'd0);

    reg_write(8'h10, 32'h100); reg_write(8'h14, 32'd32); reg_write(8'h18, 32'h100);
    reg_write(8'h20, 32'h200); reg_write(8'h24, 32'd24); reg_write(8'h28, 32'h200);

    // R2 enable
    reg_write(8'h00, 32'h1);
    @(negedge clk);
    reg_read(8'h04, d); check("R2 active bit3", d, 32'h8);
    check("R2 frm_ready", {31'd0, frm_ready}, 32'd1);

    // R9 drop with empty queues
    acc0 = n_acc;
    send_frame(16'd64, 6'd0, 15'd0, 32'd0, 1'b1);
    reg_read(8'h38, d); check("R9 drop count", d, 32'd1);
    check("R9 no memory access", n_acc, acc0);

    // R3 credits
    reg_write(8'h1C, 32'd3); reg_write(8'h1C, 32'd1);
    reg_read(8'h30, d); check("R3 desc avail", d, 32'd4);
    reg_read(8'h34, d); check("R3 sts avail untouched", d, 32'd0);
    reg_write(8'h2C, 32'd4);
    reg_read(8'h34, d); check("R3 sts avail", d, 32'd4);

    // frames: R4 R5 R6 R7 R8
    send_frame(16'd64, 6'h00, 15'd5, 32'h200, 1'b0);
    reg_read(8'h18, d); check("R7 desc cur step", d, 32'h108);
    reg_read(8'h28, d); check("R7 sts cur step", d, 32'h208);
    reg_read(8'h30, d); check("R8 desc avail", d, 32'd3);
    reg_read(8'h34, d); check("R8 sts avail", d, 32'd3);
    send_frame(16'd1514, 6'h01, 15'd6, 32'h208, 1'b0);  // R4 top bit ignored
    send_frame(16'd60, 6'h0A, 15'd7, 32'h210, 1'b0);
    send_frame(16'd100, 6'h20, 15'd8, 32'h200, 1'b0);   // status wrapped
    reg_read(8'h18, d); check("R7 desc wrap", d, 32'h100);
    reg_read(8'h28, d); check("R7 sts independent wrap", d, 32'h208);
    reg_read(8'h30, d); check("R8 desc avail zero", d, 32'd0);
    reg_read(8'h34, d); check("R8 sts avail zero", d, 32'd0);

    // R10 interrupt
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    reg_read(8'h0C, d); check("R10 pend bit2", d, 32'h4);
    reg_write(8'h08, 32'h1);
    repeat (2) @(negedge clk);
    check("R10 irq enabled", {31'd0, irq}, 32'd1);
    reg_write(8'h0C, 32'h4);
    repeat (2) @(negedge clk);
    check("R10 irq cleared", {31'd0, irq}, 32'd0);
    reg_read(8'h0C, d); check("R10 pend cleared", d, 32'h0);

    // R9 drop with only status queue empty
    reg_write(8'h1C, 32'd1);
    acc0 = n_acc;
    send_frame(16'd80, 6'h00, 15'd0, 32'd0, 1'b1);
    reg_read(8'h38, d); check("R9 drop count 2", d, 32'd2);
    check("R9 no access", n_acc, acc0);
    reg_read(8'h30, d); check("R9 desc avail kept", d, 32'd1);
    reg_read(8'h18, d); check("R9 desc cur kept", d, 32'h100);

    reg_write(8'h2C, 32'd2);
    send_frame(16'd200, 6'h14, 15'd5, 32'h208, 1'b0);
    reg_read(8'h30, d); check("R8 desc avail after", d, 32'd0);
    reg_read(8'h34, d); check("R8 sts avail after", d, 32'd1);
    check("R10 irq again", {31'd0, irq}, 32'd1);

    // R7 software rewrite of current address
    reg_write(8'h28, 32'h200);
    reg_read(8'h28, d); check("R7 cur rewrite", d, 32'h200);

    // R2 disable
    reg_write(8'h00, 32'h0);
    repeat (2) @(negedge clk);
    reg_read(8'h04, d); check("R2 inactive", d, 32'h0);
    check("R2 frm_ready low", {31'd0, frm_ready}, 32'd0);

    check("R5 scoreboard drained", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule